// File: doc/BRIEF.md
# Debug Register Access Decoder

This block serves a debug port that reads and writes processor registers through one flat register number. The number space is divided into contiguous regions: general registers first, floating registers next, then the program counter, then a large special-register space. Any number past the end of that space is unmapped. A request carries a number, a read/write flag, write data and a requested length. One clock edge later the block answers with read data and a status. The status is the requested length when the access was carried out, and zero when the access was refused.

The general and floating files are each split into a low half and a high half, and each half has its own availability flag. A special register is reachable only when its implemented flag is set. Storage is a small internal model: every general and floating register and the program counter have a word of storage. Only the lowest `SPR_STORE` special registers have storage and an implemented flag. Special registers above that count are treated as not implemented. A refused or unmapped access changes no storage at all.

Top module: `dbg_reg_access`

## Requirements
- R1: Number map with the default parameters: 0..63 select general register n, 64..127 select floating register n-64, 128 selects the program counter, and 129..4224 select special register n-129. Every number from 4225 up is unmapped. The program counter is always available.
- R2: A general-register access with index below 32 is refused when `gpr_lo_ok` is 0. One with index 32 or above is refused when `gpr_hi_ok` is 0.
- R3: A floating-register access with index below 32 is refused when `fpr_lo_ok` is 0. One with index 32 or above is refused when `fpr_hi_ok` is 0.
- R4: A special-register access with index k is refused when k >= `SPR_STORE` (256 by default) or when `spr_impl[k]` is 0.
- R5: A granted access returns `rsp_len` equal to `req_len`. A granted read returns the last value written to that register, and a granted write stores `req_wdata` there.
- R6: A refused access returns `rsp_len` = 0. A refused read returns `rsp_rdata` = 0, and every write response returns `rsp_rdata` = 0.
- R7: A read of an unmapped number returns `rsp_rdata` = 32'hDEADBEEF with `rsp_len` = 0. A write to an unmapped number changes no register and returns `rsp_len` = 0.
- R8: A refused write leaves every register unchanged. A later granted read of the targeted register returns its previous value.
- R9: A request is taken in the cycle where `req_valid` is 1. `rsp_valid` is 1 in the following cycle only, and it is 0 after any cycle without a request.
- R10: After reset every register reads 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_num | input | NUM_W (13) | Flat register number |
| req_len | input | LEN_W (8) | Length returned on success |
| req_wdata | input | 32 | Write data |
| gpr_lo_ok | input | 1 | General registers 0..31 available |
| gpr_hi_ok | input | 1 | General registers 32..63 available |
| fpr_lo_ok | input | 1 | Floating registers 0..31 available |
| fpr_hi_ok | input | 1 | Floating registers 32..63 available |
| spr_impl | input | SPR_STORE (256) | Implemented flag per stored special register |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data, filler or zero |
| rsp_len | output | LEN_W (8) | Requested length, or 0 when refused |

## Verification
The hardest case to reach from the ports is a refused write. It produces no visible change by itself, so the bench can only detect a faulty store later. The stimulus sweeps every mapped number while the availability flags take each of the four low/high combinations and the implemented bitmap has every third entry cleared. After that it reopens all flags and reads everything back against a model of storage kept in the bench. Numbers just past each region boundary and far into the unmapped space are included in the sweeps.

// File: rtl/dra_pkg.sv
package dra_pkg;
  typedef enum logic [2:0] {
    RG_GPR  = 3'd0,
    RG_FPR  = 3'd1,
    RG_PC   = 3'd2,
    RG_SPR  = 3'd3,
    RG_NONE = 3'd4
  } region_e;

  localparam logic [31:0] FILLER_WORD = 32'hDEADBEEF;
endpackage

// File: rtl/dra_decode.sv
module dra_decode
  import dra_pkg::*;
#(
  parameter int GPR_COUNT = 64,
  parameter int FPR_COUNT = 64,
  parameter int SPR_COUNT = 4096,
  parameter int SPR_STORE = 256,
  parameter int NUM_W     = 13,
  parameter int IDX_W     = 12
) (
  input  logic [NUM_W-1:0]     num,
  input  logic                 gpr_lo_ok,
  input  logic                 gpr_hi_ok,
  input  logic                 fpr_lo_ok,
  input  logic                 fpr_hi_ok,
  input  logic [SPR_STORE-1:0] spr_impl,
  output region_e              region,
  output logic [IDX_W-1:0]     idx,
  output logic                 grant
);
  localparam int FBASE = GPR_COUNT;
  localparam int PCNUM = GPR_COUNT + FPR_COUNT;
  localparam int SBASE = PCNUM + 1;
  localparam int SEND  = SBASE + SPR_COUNT;
  localparam int SIW   = (SPR_STORE > 1) ? $clog2(SPR_STORE) : 1;

  function automatic region_e classify(input logic [31:0] n);
    if (n < 32'(FBASE))      return RG_GPR;
    else if (n < 32'(PCNUM)) return RG_FPR;
    else if (n == 32'(PCNUM)) return RG_PC;
    else if (n < 32'(SEND))  return RG_SPR;
    else                     return RG_NONE;
  endfunction

  function automatic logic [31:0] base_of(input region_e r);
    case (r)
      RG_FPR:  return 32'(FBASE);
      RG_PC:   return 32'(PCNUM);
      RG_SPR:  return 32'(SBASE);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic half_ok(input logic [31:0] i, input int count,
                                   input logic lo, input logic hi);
    return (i < 32'(count / 2)) ? lo : hi;
  endfunction

  logic [31:0] num32;
  logic [31:0] off32;

  always_comb begin
    num32  = 32'(num);
    region = classify(num32);
    off32  = num32 - base_of(region);
    idx    = IDX_W'(off32);
    case (region)
      RG_GPR:  grant = half_ok(off32, GPR_COUNT, gpr_lo_ok, gpr_hi_ok);
      RG_FPR:  grant = half_ok(off32, FPR_COUNT, fpr_lo_ok, fpr_hi_ok);
      RG_PC:   grant = 1'b1;
      RG_SPR:  grant = (off32 < 32'(SPR_STORE)) && spr_impl[off32[SIW-1:0]];
      default: grant = 1'b0;
    endcase
  end

  always_comb begin
    a_r1_none_never_granted: assert (!(region == RG_NONE && grant));
  end
endmodule

// File: rtl/dra_bank.sv
module dra_bank #(
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic in_range;
  assign in_range = (32'(idx) < DEPTH);

  generate
    if (DEPTH == 1) begin : g_single
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             word_q <= '0;
        else if (we && in_range) word_q <= wdata;
      end
      assign rdata = in_range ? word_q : '0;
    end else begin : g_array
      logic [DATA_W-1:0] mem_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we && in_range) begin
          mem_q[idx[IW-1:0]] <= wdata;
        end
      end
      assign rdata = in_range ? mem_q[idx[IW-1:0]] : '0;
    end
  endgenerate

  // R5: a write is visible to a read of the same index on the next cycle
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && $past(in_range) && idx == $past(idx)) |-> rdata == $past(wdata));
  // R8: without a write, a steady index reads a steady value
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(we) && $stable(idx)) |-> $stable(rdata));
endmodule

// File: rtl/dra_resp.sv
module dra_resp
  import dra_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             write,
  input  logic             grant,
  input  region_e          region,
  input  logic [31:0]      bank_rdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic [LEN_W-1:0] rsp_len
);
  function automatic logic [31:0] pick_data(input logic wr, input logic ok,
                                            input region_e r, input logic [31:0] d);
    if (wr)                return 32'd0;
    else if (r == RG_NONE) return FILLER_WORD;
    else if (ok)           return d;
    else                   return 32'd0;
  endfunction

  logic [31:0]      data_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    data_d = pick_data(write, grant, region, bank_rdata);
    len_d  = grant ? req_len : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_len   <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_rdata <= data_d;
        rsp_len   <= len_d;
      end
    end
  end
endmodule

// File: rtl/dbg_reg_access.sv
module dbg_reg_access
  import dra_pkg::*;
#(
  parameter int GPR_COUNT = 64,
  parameter int FPR_COUNT = 64,
  parameter int SPR_COUNT = 4096,
  parameter int SPR_STORE = 256,
  parameter int LEN_W     = 8,
  parameter int NUM_W     = $clog2(GPR_COUNT + FPR_COUNT + 1 + SPR_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [NUM_W-1:0]     req_num,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [31:0]          req_wdata,
  input  logic                 gpr_lo_ok,
  input  logic                 gpr_hi_ok,
  input  logic                 fpr_lo_ok,
  input  logic                 fpr_hi_ok,
  input  logic [SPR_STORE-1:0] spr_impl,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [LEN_W-1:0]     rsp_len
);
  localparam int MAXF  = (GPR_COUNT > FPR_COUNT) ? GPR_COUNT : FPR_COUNT;
  localparam int MAXI  = (MAXF > SPR_COUNT) ? MAXF : SPR_COUNT;
  localparam int IDX_W = (MAXI > 1) ? $clog2(MAXI) : 1;

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic             grant;
  logic             wr_fire;
  logic             we_gpr, we_fpr, we_pc, we_spr;
  logic [31:0]      rd_gpr, rd_fpr, rd_pc, rd_spr, rd_sel;

  dra_decode #(
    .GPR_COUNT(GPR_COUNT), .FPR_COUNT(FPR_COUNT), .SPR_COUNT(SPR_COUNT),
    .SPR_STORE(SPR_STORE), .NUM_W(NUM_W), .IDX_W(IDX_W)
  ) u_dec (
    .num(req_num), .gpr_lo_ok(gpr_lo_ok), .gpr_hi_ok(gpr_hi_ok),
    .fpr_lo_ok(fpr_lo_ok), .fpr_hi_ok(fpr_hi_ok), .spr_impl(spr_impl),
    .region(region), .idx(idx), .grant(grant)
  );

  assign wr_fire = req_valid && req_write && grant;
  assign we_gpr  = wr_fire && (region == RG_GPR);
  assign we_fpr  = wr_fire && (region == RG_FPR);
  assign we_pc   = wr_fire && (region == RG_PC);
  assign we_spr  = wr_fire && (region == RG_SPR);

  dra_bank #(.DEPTH(GPR_COUNT), .IDX_W(IDX_W)) u_gpr (
    .clk(clk), .rst_n(rst_n), .we(we_gpr), .idx(idx), .wdata(req_wdata), .rdata(rd_gpr));
  dra_bank #(.DEPTH(FPR_COUNT), .IDX_W(IDX_W)) u_fpr (
    .clk(clk), .rst_n(rst_n), .we(we_fpr), .idx(idx), .wdata(req_wdata), .rdata(rd_fpr));
  dra_bank #(.DEPTH(1), .IDX_W(IDX_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .we(we_pc), .idx(idx), .wdata(req_wdata), .rdata(rd_pc));
  dra_bank #(.DEPTH(SPR_STORE), .IDX_W(IDX_W)) u_spr (
    .clk(clk), .rst_n(rst_n), .we(we_spr), .idx(idx), .wdata(req_wdata), .rdata(rd_spr));

  always_comb begin
    case (region)
      RG_GPR:  rd_sel = rd_gpr;
      RG_FPR:  rd_sel = rd_fpr;
      RG_PC:   rd_sel = rd_pc;
      RG_SPR:  rd_sel = rd_spr;
      default: rd_sel = 32'd0;
    endcase
  end

  dra_resp #(.LEN_W(LEN_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .fire(req_valid), .write(req_write), .grant(grant),
    .region(region), .bank_rdata(rd_sel), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_len(rsp_len)
  );

  // R8: at most one bank is written per cycle
  a_r8_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_gpr, we_fpr, we_pc, we_spr}));
  // R9: every request gets a response next cycle, and only then
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R5/R6: status is the requested length or zero
  a_r5_len_echo: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_len == '0 || rsp_len == $past(req_len)));
  // R7: unmapped reads carry the filler word with zero status
  a_r7_filler: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && region == RG_NONE) |=>
      (rsp_rdata == FILLER_WORD && rsp_len == '0));
  // R2: low half of general file is gated by its flag
  a_r2_gpr_lo_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && region == RG_GPR && 32'(idx) < GPR_COUNT / 2 && !gpr_lo_ok) |=>
      rsp_len == '0);
  // R3: high half of floating file is gated by its flag
  a_r3_fpr_hi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && region == RG_FPR && 32'(idx) >= FPR_COUNT / 2 && !fpr_hi_ok) |=>
      rsp_len == '0);
endmodule

// File: tb/sim_dbg_reg_access.sv
`timescale 1ns/1ps
module sim_dbg_reg_access;
  localparam int NW  = 13;
  localparam int LW  = 8;
  localparam int SST = 256;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [NW-1:0]   req_num = '0;
  logic [LW-1:0]   req_len = '0;
  logic [31:0]     req_wdata = '0;
  logic            gpr_lo_ok = 1'b1, gpr_hi_ok = 1'b1, fpr_lo_ok = 1'b1, fpr_hi_ok = 1'b1;
  logic [SST-1:0]  spr_impl = '1;
  logic            rsp_valid;
  logic [31:0]     rsp_rdata;
  logic [LW-1:0]   rsp_len;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  logic [31:0] gm [64];
  logic [31:0] fm [64];
  logic [31:0] pm;
  logic [31:0] sm [SST];

  always #5 clk = ~clk;

  dbg_reg_access u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_num(req_num), .req_len(req_len), .req_wdata(req_wdata),
    .gpr_lo_ok(gpr_lo_ok), .gpr_hi_ok(gpr_hi_ok), .fpr_lo_ok(fpr_lo_ok),
    .fpr_hi_ok(fpr_hi_ok), .spr_impl(spr_impl),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_len(rsp_len));

  // region: 0 gpr, 1 fpr, 2 pc, 3 spr, 4 unmapped  (R1)
  function automatic int region_of(input int n);
    if (n < 64) return 0;
    if (n < 128) return 1;
    if (n == 128) return 2;
    if (n < 129 + 4096) return 3;
    return 4;
  endfunction

  function automatic string tag_of(input int r);
    case (r)
      0: return "R2";
      1: return "R3";
      2: return "R1";
      3: return "R4";
      default: return "R7";
    endcase
  endfunction

  function automatic bit allowed(input int n);
    int r = region_of(n);
    int k;
    case (r)
      0: return (n < 32) ? gpr_lo_ok : gpr_hi_ok;
      1: begin k = n - 64; return (k < 32) ? fpr_lo_ok : fpr_hi_ok; end
      2: return 1'b1;
      3: begin k = n - 129; return (k < SST) ? spr_impl[k] : 1'b0; end
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] model_rd(input int n);
    case (region_of(n))
      0: return gm[n];
      1: return fm[n - 64];
      2: return pm;
      3: return sm[n - 129];
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_wr(input int n, input logic [31:0] v);
    case (region_of(n))
      0: gm[n] = v;
      1: fm[n - 64] = v;
      2: pm = v;
      3: sm[n - 129] = v;
      default: ;
    endcase
  endtask

  task automatic check(input bit ok, input string tg, input string what,
                       input logic [31:0] act, input logic [31:0] exp, input int n);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s num=%0d actual=%h expected=%h", tg, what, n, act, exp);
    end
  endtask

  task automatic do_acc(input int n, input bit wr, input logic [31:0] wd);
    int ln = (n % 7) + 1;
    int r = region_of(n);
    bit ok = allowed(n);
    logic [31:0] ed;
    logic [LW-1:0] el;
    string tg = tag_of(r);
    el = ok ? LW'(ln) : '0;
    if (wr) ed = 32'd0;
    else if (r == 4) ed = 32'hDEADBEEF;
    else if (ok) ed = model_rd(n);
    else ed = 32'd0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_num = NW'(n);
    req_len = LW'(ln); req_wdata = wd;
    @(posedge clk); #1;
    check(rsp_valid === 1'b1, "R9", "rsp_valid", 32'(rsp_valid), 32'd1, n);
    check(rsp_len === el, ok ? "R5" : tg, "len", 32'(rsp_len), 32'(el), n);
    check(rsp_rdata === ed, (ok && !wr) ? "R5" : (wr ? "R6" : tg), "data", rsp_rdata, ed, n);
    if (wr && ok) model_wr(n, wd);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    check(rsp_valid === 1'b0, "R9", "idle", 32'(rsp_valid), 32'd0, n);
  endtask

  function automatic logic [31:0] pat(input int n, input int salt);
    return (32'(n) * 32'h9E3779B1) ^ (32'(salt) * 32'h01010101) ^ 32'h5A5A0000;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin gm[i] = 0; fm[i] = 0; end
    for (int i = 0; i < SST; i++) sm[i] = 0;
    pm = 0;
    repeat (3) @(posedge clk);
    #1;
    check(rsp_valid === 1'b0, "R10", "reset rsp_valid", 32'(rsp_valid), 0, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(rsp_valid === 1'b0, "R10", "post-reset rsp_valid", 32'(rsp_valid), 0, 0);
    // R10: reset contents read zero
    do_acc(0, 0, 0); do_acc(63, 0, 0); do_acc(64, 0, 0); do_acc(128, 0, 0); do_acc(129, 0, 0);

    // Phase A: sparse implemented map, write everything, read back  (R1 R4 R5 R7)
    @(negedge clk);
    for (int i = 0; i < SST; i++) spr_impl[i] = (i % 3 != 0);
    for (int n = 0; n < 4240; n++) do_acc(n, 1, pat(n, 1));
    do_acc(6000, 1, 32'h1234_5678); do_acc(8191, 1, 32'hFFFF_FFFF);
    for (int n = 0; n < 4240; n++) do_acc(n, 0, 0);
    do_acc(6000, 0, 0); do_acc(8191, 0, 0);
    // R8: reopen all special flags, refused entries must still hold zero
    @(negedge clk); spr_impl = '1;
    for (int n = 129; n < 129 + SST + 4; n++) do_acc(n, 0, 0);

    // Phase B: all four half-availability combinations  (R2 R3 R8)
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      gpr_lo_ok = c[0]; gpr_hi_ok = c[1];
      fpr_lo_ok = ~c[1]; fpr_hi_ok = c[0];
      for (int n = 0; n < 130; n++) do_acc(n, 1, pat(n, c + 2));
      for (int n = 0; n < 130; n++) do_acc(n, 0, 0);
    end
    @(negedge clk);
    gpr_lo_ok = 1; gpr_hi_ok = 1; fpr_lo_ok = 1; fpr_hi_ok = 1;
    for (int n = 0; n < 130; n++) do_acc(n, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule